// File: doc/BRIEF.md
# Event-Combination Reset Generator

This block drives two independent reset outputs. Each channel watches a small set of already-synchronized event levels, filtered by its own enable mask. When every enabled event of a channel is high in the same cycle and stays high for a selectable hold time, the channel emits one reset pulse. The pulse width and the output polarity are also selectable. Channel A combines up to three events and channel B up to two.

Hold time and pulse width are counted in ticks of `tick_i`, which is a single-cycle strobe that is normally one millisecond apart. The parameter `HALF_SEC_TICKS` sets how many ticks make half a second. Hold codes select no wait, or 1, 1.5, 2, 2.5, 3, 3.5 or 4 seconds. Width selects give 0.5, 1, 2 or 4 seconds. After a pulse ends, the channel stays parked until its enabled events have all been released. Holding a key combination down therefore produces one reset and never a train of resets.

Top module: `evt_rst_gen`

## Requirements
- R1: The two channels are independent. Channel A uses a 3-bit event and mask pair and channel B uses a 2-bit pair. Activity on one channel never changes the output of the other.
- R2: A channel qualifies only while its mask is nonzero and every event whose mask bit is 1 is high in the same cycle. Events whose mask bit is 0 are ignored.
- R3: The 3-bit hold code gives L ticks, with H = `HALF_SEC_TICKS`. Code 0 gives L = 0 and code k (1..7) gives L = (k+1)·H. Events that first qualify at clock edge e make the output active from edge e+L onward, provided they stay qualified.
- R4: The 2-bit width select s gives a pulse that lasts H·2^s ticks. It starts in the cycle after the qualifying cycle.
- R5: If any enabled event drops before the hold time has elapsed, the hold timer restarts from zero at the next qualification.
- R6: A channel whose mask is all zero never fires.
- R7: After a pulse, a channel does not fire again until all of its enabled events are low at the same time. Releasing only some of the events is not enough.
- R8: A polarity input of 1 makes the reset active-high and 0 makes it active-low. After reset, both outputs sit at their inactive level.
- R9: The hold timer advances only on cycles where `tick_i` is 1. Without ticks, a nonzero hold time never completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base strobe, one cycle per tick |
| evt_a_i | input | 3 | Channel A event levels |
| en_a_i | input | 3 | Channel A event enable mask |
| hold_a_i | input | 3 | Channel A hold-time code |
| width_a_i | input | 2 | Channel A pulse width select |
| pol_a_i | input | 1 | Channel A polarity, 1 = active-high |
| evt_b_i | input | 2 | Channel B event levels |
| en_b_i | input | 2 | Channel B event enable mask |
| hold_b_i | input | 3 | Channel B hold-time code |
| width_b_i | input | 2 | Channel B pulse width select |
| pol_b_i | input | 1 | Channel B polarity, 1 = active-high |
| rst_a_o | output | 1 | Channel A reset output |
| rst_b_o | output | 1 | Channel B reset output |

## Verification
The bench builds the block with `HALF_SEC_TICKS` = 4 and keeps `tick_i` high on every cycle except in the tick-gating test. With these values the longest hold (code 7, 32 ticks) and the widest pulse (select 3, 32 ticks) complete in a few dozen cycles. Every hold code and width select is therefore reachable within a short run, and the exact latency and width can be checked to the cycle. Channel A runs active-high and channel B active-low, so both polarities are covered at the same time.

// File: rtl/evt_rst_pkg.sv
package evt_rst_pkg;

  typedef enum logic [1:0] {
    ST_ARM   = 2'd0,
    ST_PULSE = 2'd1,
    ST_WAIT  = 2'd2
  } ch_state_e;

  // hold code -> ticks: 0 -> 0, k -> (k+1) half-seconds
  function automatic int unsigned hold_ticks(input logic [2:0] code, input int unsigned half);
    return (code == 3'd0) ? 32'd0 : (32'(code) + 32'd1) * half;
  endfunction

  // width select -> ticks: half-second << sel
  function automatic int unsigned pulse_ticks(input logic [1:0] sel, input int unsigned half);
    return half << sel;
  endfunction

endpackage

// File: rtl/erg_hold_timer.sv
module erg_hold_timer
  import evt_rst_pkg::*;
#(
  parameter int unsigned N    = 3,
  parameter int unsigned HALF = 500,
  localparam int unsigned CW  = $clog2(8 * HALF + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         armed_i,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] en_i,
  input  logic [2:0]   code_i,
  output logic         all_on_o,
  output logic         fire_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit    = CW'(hold_ticks(code_i, HALF));
  assign all_on_o = (|en_i) && ((evt_i & en_i) == en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!armed_i || !all_on_o) begin
      cnt_q <= '0;
    end else if (tick_i && cnt_q < limit) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fire_o = armed_i && all_on_o && (cnt_q >= limit);

endmodule

// File: rtl/erg_pulse_fsm.sv
module erg_pulse_fsm
  import evt_rst_pkg::*;
#(
  parameter int unsigned HALF = 500,
  localparam int unsigned PW  = $clog2(8 * HALF + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       fire_i,
  input  logic       any_on_i,
  input  logic [1:0] sel_i,
  input  logic       pol_i,
  output logic       armed_o,
  output logic       active_o,
  output logic       rst_o
);

  ch_state_e     state_q, state_d;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic [PW-1:0] plen;

  assign plen = PW'(pulse_ticks(sel_i, HALF));

  always_comb begin
    state_d = state_q;
    pcnt_d  = pcnt_q;
    unique case (state_q)
      ST_ARM: begin
        if (fire_i) begin
          state_d = ST_PULSE;
          pcnt_d  = '0;
        end
      end
      ST_PULSE: begin
        if (tick_i) begin
          if (pcnt_q >= plen - 1'b1) state_d = ST_WAIT;
          else                       pcnt_d  = pcnt_q + 1'b1;
        end
      end
      ST_WAIT: begin
        // re-arm only after every enabled event is released
        if (!any_on_i) state_d = ST_ARM;
      end
      default: state_d = ST_ARM;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ARM;
      pcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      pcnt_q  <= pcnt_d;
    end
  end

  assign armed_o  = (state_q == ST_ARM);
  assign active_o = (state_q == ST_PULSE);
  assign rst_o    = pol_i ? active_o : ~active_o;

endmodule

// File: rtl/erg_channel.sv
module erg_channel
  import evt_rst_pkg::*;
#(
  parameter int unsigned N    = 3,
  parameter int unsigned HALF = 500
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] en_i,
  input  logic [2:0]   hold_i,
  input  logic [1:0]   width_i,
  input  logic         pol_i,
  output logic         rst_o,
  output logic         fire_o,
  output logic         active_o,
  output logic         all_on_o
);

  logic armed;
  logic any_on;

  assign any_on = |(evt_i & en_i);

  erg_hold_timer #(.N(N), .HALF(HALF)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .armed_i  (armed),
    .evt_i    (evt_i),
    .en_i     (en_i),
    .code_i   (hold_i),
    .all_on_o (all_on_o),
    .fire_o   (fire_o)
  );

  erg_pulse_fsm #(.HALF(HALF)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .fire_i   (fire_o),
    .any_on_i (any_on),
    .sel_i    (width_i),
    .pol_i    (pol_i),
    .armed_o  (armed),
    .active_o (active_o),
    .rst_o    (rst_o)
  );

endmodule

// File: rtl/evt_rst_gen.sv
module evt_rst_gen
  import evt_rst_pkg::*;
#(
  parameter int unsigned HALF_SEC_TICKS = 500,
  parameter int unsigned NA = 3,
  parameter int unsigned NB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [NA-1:0] evt_a_i,
  input  logic [NA-1:0] en_a_i,
  input  logic [2:0]    hold_a_i,
  input  logic [1:0]    width_a_i,
  input  logic          pol_a_i,
  input  logic [NB-1:0] evt_b_i,
  input  logic [NB-1:0] en_b_i,
  input  logic [2:0]    hold_b_i,
  input  logic [1:0]    width_b_i,
  input  logic          pol_b_i,
  output logic          rst_a_o,
  output logic          rst_b_o
);

  logic a_fire, a_active, a_all_on;
  logic b_fire, b_active, b_all_on;

  erg_channel #(.N(NA), .HALF(HALF_SEC_TICKS)) u_ch_a (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .evt_i    (evt_a_i),
    .en_i     (en_a_i),
    .hold_i   (hold_a_i),
    .width_i  (width_a_i),
    .pol_i    (pol_a_i),
    .rst_o    (rst_a_o),
    .fire_o   (a_fire),
    .active_o (a_active),
    .all_on_o (a_all_on)
  );

  erg_channel #(.N(NB), .HALF(HALF_SEC_TICKS)) u_ch_b (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .evt_i    (evt_b_i),
    .en_i     (en_b_i),
    .hold_i   (hold_b_i),
    .width_i  (width_b_i),
    .pol_i    (pol_b_i),
    .rst_o    (rst_b_o),
    .fire_o   (b_fire),
    .active_o (b_active),
    .all_on_o (b_all_on)
  );

endmodule

// File: rtl/erg_checker.sv
module erg_checker #(
  parameter int unsigned NA = 3,
  parameter int unsigned NB = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NA-1:0] evt_a_i,
  input logic [NA-1:0] en_a_i,
  input logic [2:0]    hold_a_i,
  input logic [NB-1:0] evt_b_i,
  input logic [NB-1:0] en_b_i,
  input logic          a_fire,
  input logic          a_active,
  input logic          a_all_on,
  input logic          b_fire,
  input logic          b_active
);

  AST_A_FIRE_ALL_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_fire |-> ((evt_a_i & en_a_i) == en_a_i)); // R2

  AST_B_FIRE_ALL_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_fire |-> ((evt_b_i & en_b_i) == en_b_i)); // R2

  AST_A_MASK_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_a_i == '0) |-> !a_fire); // R6

  AST_B_MASK_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_b_i == '0) |-> !b_fire); // R6

  AST_A_PULSE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_fire |=> a_active); // R4

  AST_B_PULSE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_fire |=> b_active); // R4

  AST_A_HELD_BEFORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(a_active) && hold_a_i != 3'd0) |-> $past(a_all_on, 2)); // R3

endmodule

bind evt_rst_gen erg_checker #(.NA(NA), .NB(NB)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .evt_a_i  (evt_a_i),
  .en_a_i   (en_a_i),
  .hold_a_i (hold_a_i),
  .evt_b_i  (evt_b_i),
  .en_b_i   (en_b_i),
  .a_fire   (a_fire),
  .a_active (a_active),
  .a_all_on (a_all_on),
  .b_fire   (b_fire),
  .b_active (b_active)
);

// File: tb/sim_evt_rst_gen.sv
`timescale 1ns/1ps
module sim_evt_rst_gen;

  localparam int H = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [2:0] evt_a = '0, en_a = 3'b111, hold_a = 3'd1;
  logic [1:0] width_a = 2'd0;
  logic       pol_a = 1'b1;
  logic [1:0] evt_b = '0, en_b = 2'b11;
  logic [2:0] hold_b = 3'd7;
  logic [1:0] width_b = 2'd3;
  logic       pol_b = 1'b0;
  logic       rst_a, rst_b;

  always #4 clk = ~clk;

  evt_rst_gen #(.HALF_SEC_TICKS(H)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .evt_a_i(evt_a), .en_a_i(en_a), .hold_a_i(hold_a), .width_a_i(width_a), .pol_a_i(pol_a),
    .evt_b_i(evt_b), .en_b_i(en_b), .hold_b_i(hold_b), .width_b_i(width_b), .pol_b_i(pol_b),
    .rst_a_o(rst_a), .rst_b_o(rst_b)
  );

  typedef struct {
    int    t0;
    int    lat;
    int    w;
    string tag;
  } exp_t;

  exp_t q_a[$];
  exp_t q_b[$];
  int   cyc = 0;
  int   n_run = 0, n_fail = 0;
  int   pulses_a = 0, pulses_b = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp_v);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic push_a(input int t0, input int lat, input int w, input string tag);
    exp_t e;
    e.t0 = t0; e.lat = lat; e.w = w; e.tag = tag;
    q_a.push_back(e);
  endtask

  task automatic push_b(input int t0, input int lat, input int w, input string tag);
    exp_t e;
    e.t0 = t0; e.lat = lat; e.w = w; e.tag = tag;
    q_b.push_back(e);
  endtask

  // monitor: measure each pulse and compare against the scoreboard
  bit prev_a = 0, prev_b = 0;
  int start_a = 0, start_b = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      bit act_a, act_b;
      exp_t e;
      act_a = pol_a ? rst_a : ~rst_a;
      act_b = pol_b ? rst_b : ~rst_b;
      if (act_a && !prev_a) start_a = cyc;
      if (!act_a && prev_a) begin
        pulses_a++;
        if (q_a.size() == 0) check(0, "R1 unexpected pulse on A", cyc - start_a, 0);
        else begin
          e = q_a.pop_front();
          check(start_a - e.t0 == e.lat, {e.tag, " latency"}, start_a - e.t0, e.lat);
          check(cyc - start_a == e.w, {e.tag, " width"}, cyc - start_a, e.w);
        end
      end
      if (act_b && !prev_b) start_b = cyc;
      if (!act_b && prev_b) begin
        pulses_b++;
        if (q_b.size() == 0) check(0, "R1 unexpected pulse on B", cyc - start_b, 0);
        else begin
          e = q_b.pop_front();
          check(start_b - e.t0 == e.lat, {e.tag, " latency"}, start_b - e.t0, e.lat);
          check(cyc - start_b == e.w, {e.tag, " width"}, cyc - start_b, e.w);
        end
      end
      prev_a = act_a;
      prev_b = act_b;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_a(input int n);
    while (pulses_a < n) @(negedge clk);
  endtask

  task automatic wait_b(input int n);
    while (pulses_b < n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    idle(3);
    check(rst_a === 1'b0, "R8 idle level A after reset", int'(rst_a), 0);
    check(rst_b === 1'b1, "R8 idle level B after reset", int'(rst_b), 1);
    rst_n = 1'b1;
    idle(3);

    // R3/R4: code 1 -> 8 ticks, width 0 -> 4 ticks
    evt_a = 3'b111; push_a(cyc, 9, 4, "R3 code1 hold");
    wait_a(1); evt_a = '0; idle(3);

    // R2: masked-out event ignored, code 0, width 1 -> 8
    en_a = 3'b101; hold_a = 3'd0; width_a = 2'd1;
    evt_a = 3'b101; push_a(cyc, 1, 8, "R2 masked event ignored");
    wait_a(2); evt_a = '0; idle(3);

    // R5: drop during qualification restarts timer (code 2 -> 12)
    en_a = 3'b111; hold_a = 3'd2; width_a = 2'd0;
    evt_a = 3'b111; idle(6);
    evt_a = 3'b110; idle(1);
    evt_a = 3'b111; push_a(cyc, 13, 4, "R5 timer restart");
    wait_a(3); evt_a = '0; idle(3);

    // R2: partial combination never fires
    evt_a = 3'b011; idle(50);
    check(pulses_a == 3, "R2 partial combination", pulses_a, 3);
    evt_a = '0; idle(2);

    // R6: empty mask never fires
    en_a = 3'b000; evt_a = 3'b111; idle(50);
    check(pulses_a == 3, "R6 empty mask", pulses_a, 3);
    evt_a = '0; en_a = 3'b111; idle(2);

    // R7: no re-arm until all enabled events released
    hold_a = 3'd0;
    evt_a = 3'b111; push_a(cyc, 1, 4, "R7 first pulse");
    wait_a(4); idle(30);
    check(pulses_a == 4, "R7 held events no refire", pulses_a, 4);
    evt_a = 3'b011; idle(1); evt_a = 3'b111; idle(30);
    check(pulses_a == 4, "R7 partial release no refire", pulses_a, 4);
    evt_a = '0; idle(2);
    evt_a = 3'b111; push_a(cyc, 1, 4, "R7 rearm after release");
    wait_a(5); evt_a = '0; idle(3);

    // R9: no ticks, no progress
    hold_a = 3'd1; tick = 1'b0;
    evt_a = 3'b111; idle(40);
    check(pulses_a == 5, "R9 no tick no fire", pulses_a, 5);
    tick = 1'b1; push_a(cyc, 9, 4, "R9 tick resumes");
    wait_a(6); evt_a = '0; idle(3);

    // R1/R8: channel B active-low, code 7 -> 32, width 3 -> 32
    evt_b = 2'b11; push_b(cyc, 33, 32, "R3 code7 on B");
    idle(33);
    check(rst_b === 1'b0, "R8 B active-low during pulse", int'(rst_b), 0);
    check(rst_a === 1'b0, "R1 A unaffected by B", int'(rst_a), 0);
    wait_b(1); evt_b = '0; idle(3);
    check(pulses_a == 6, "R1 A pulse count unchanged", pulses_a, 6);

    // R2 on B: single enabled event
    en_b = 2'b01; hold_b = 3'd0; width_b = 2'd0;
    evt_b = 2'b01; push_b(cyc, 1, 4, "R2 B single event");
    wait_b(2); evt_b = '0; idle(3);

    check(q_a.size() == 0, "R4 A scoreboard drained", q_a.size(), 0);
    check(q_b.size() == 0, "R4 B scoreboard drained", q_b.size(), 0);
    finish_run();
  end

endmodule